// File: doc/BRIEF.md
# Dual Down-Counter Interval Timer with Interrupt Flags

This block holds two 16-bit down-counters and the flag and enable logic that raises one interrupt line. Host software reaches it over a byte-wide register bus with a 4-bit address. A register write acts on the clock edge of the cycle in which `cs_wr` is high. A register read is combinational while `cs_rd` is high, and any side effect of the read takes place on the same edge.

The first counter has a 16-bit latch. It runs either one-shot or free-running, and in free-running mode it reloads from its latch each time it expires. The second counter is a one-shot interval timer. Its value is assembled in a latch one byte at a time, and writing the upper byte starts it. Each counter decrements only in cycles where its own tick input is high, so the two can run at unrelated rates.

The flag register also holds a serial-transfer flag, which can only be set through a test input.

Top module: `tmr_irq_core`

Address map: 0 first-counter count low, 1 first-counter count high, 2 first-counter latch low, 3 first-counter latch high, 4 second-counter count low, 5 second-counter count high, 6 mode, 7 flags, 8 enables. Any other address reads 0.

The block has two states per counter:
- ARMED: an expiry raises the flag.
- SPENT: the counter keeps running but raises nothing.

It moves between them on these transitions:
- `load` (a count-high write) goes from any state to ARMED.
- `expire_oneshot` goes from ARMED to SPENT.
- `expire_reload` stays in ARMED; it is taken only by the first counter in free-running mode.

## Requirements
- R1: After reset:
  - both latches hold 0xFFFF;
  - the first counter holds 0xFFFF;
  - both counters are SPENT;
  - flags, enables and mode read 0.
- R2: A write to address 4 changes only latch bits 7:0 of the second counter. Its counter is unchanged.
- R3: A write to address 5 does three things in the same cycle:
  - puts the data in latch bits 15:8;
  - loads the whole new latch into the second counter and arms it;
  - clears the second counter's flag.
- R4: A read of address 4 returns counter bits 7:0 of the second counter and clears its flag.
- R5: A read of address 5 returns counter bits 15:8 of the second counter and leaves its flag unchanged.
- R6: After loading N, the second counter's flag sets on tick N+1. That is the tick taken while the count is 0, which moves the count to 0xFFFF.
- R7: After it expires, the second counter keeps decrementing and wraps without reloading. It sets no flag again until it is reloaded.
- R8: With mode bit 0 clear, the first counter raises at most one flag per load and then wraps to 0xFFFF. Reading address 0 clears its flag.
- R9: With mode bit 0 set, the first counter flags on every expiry and reloads from its latch, so it flags every N+1 ticks.
- R10: `t1_tick` moves only the first counter and `t2_tick` moves only the second.
- R11: The flag register (address 7) has these fields:
  - bit 2 is the serial-transfer flag, bit 5 the second counter's flag and bit 6 the first counter's flag;
  - bit 7 reads the `irq` level;
  - writing a 1 clears a flag bit;
  - `sr_set` sets bit 2, and a set wins over a clear in the same cycle.
- R12: On a write to the enable register (address 8), bit 7 = 1 sets every enable bit written as 1, and bit 7 = 0 clears them. Reads return bits 2, 5 and 6, with bit 7 reading 0.
- R13: `irq` is high exactly when some flag among bits 2, 5 and 6 is set and its enable is set.
- R14: The first counter's registers behave as follows:
  - a write to address 0 or 2 sets latch bits 7:0;
  - a write to address 3 sets latch bits 15:8 only;
  - a write to address 1 sets latch bits 15:8, loads the counter from the latch, arms it and clears its flag;
  - addresses 2 and 3 read back the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_tick | input | 1 | Decrement enable for the first counter |
| t2_tick | input | 1 | Decrement enable for the second counter |
| sr_set | input | 1 | Test input that sets the serial-transfer flag |
| cs_wr | input | 1 | Register write strobe |
| cs_rd | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when `cs_rd` is low |
| irq | output | 1 | Interrupt request |

## Verification
A counter left in the wrong state shows up within one expiry:
- a counter wrongly held ARMED after a one-shot expiry raises a second flag on the next zero crossing;
- a counter wrongly left SPENT never raises one.

A wrongly assembled latch or a wrong load order shows in the count read back on the cycle right after the high-byte write. A flag or enable bit in the wrong state shows at `irq` in the same cycle, and the sweep over all flag and enable combinations exposes any bit routed to the wrong position.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_T1_CLO = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_T1_CHI = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_T1_LLO = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_T1_LHI = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_T2_CLO = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_T2_CHI = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 4'd8;

    // Interrupt sources, as an index into the flag vector
    localparam int NSRC   = 3;
    localparam int SRC_SR = 0;
    localparam int SRC_T2 = 1;
    localparam int SRC_T1 = 2;

    // Bit positions in the flag and enable bytes
    localparam int BIT_SR  = 2;
    localparam int BIT_T2  = 5;
    localparam int BIT_T1  = 6;
    localparam int BIT_TOP = 7;

    typedef enum logic {
        CNT_SPENT = 1'b0,
        CNT_ARMED = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt
    import tmr_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter bit                CAN_RELOAD = 1'b0,
    parameter logic [2*DATA_W-1:0] RST_CNT  = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  cont_mode,
    input  logic                  lat_lo_we,
    input  logic                  lat_hi_we,
    input  logic                  load_go,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   count,
    output logic [2*DATA_W-1:0]   latch,
    output logic                  expire
);

    localparam int                CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0]  ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   lat_q, lat_d;
    logic               at_zero;
    logic               reload_ok;

    assign at_zero   = (cnt_q == '0);
    assign reload_ok = CAN_RELOAD && cont_mode;

    // Latch assembly: byte halves may be written separately
    always_comb begin
        lat_d = lat_q;
        if (lat_lo_we) lat_d[DATA_W-1:0]     = wdata;
        if (lat_hi_we) lat_d[CNT_W-1:DATA_W] = wdata;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (load_go) begin
            state_d = CNT_ARMED;                       // load
        end else if (tick && at_zero) begin
            unique case (state_q)
                CNT_ARMED: state_d = reload_ok ? CNT_ARMED   // expire_reload
                                               : CNT_SPENT;  // expire_oneshot
                CNT_SPENT: state_d = CNT_SPENT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_SPENT;
        else        state_q <= state_d;
    end

    // Outputs: counter datapath and expiry pulse
    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load_go) begin
            cnt_d = lat_d;
        end else if (tick) begin
            unique case (state_q)
                CNT_ARMED: begin
                    if (at_zero) begin
                        expire = 1'b1;
                        cnt_d  = reload_ok ? lat_q : cnt_q - ONE;
                    end else begin
                        cnt_d  = cnt_q - ONE;
                    end
                end
                CNT_SPENT: cnt_d = cnt_q - ONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
            lat_q <= '1;
        end else begin
            cnt_q <= cnt_d;
            lat_q <= lat_d;
        end
    end

    assign count = cnt_q;
    assign latch = lat_q;

endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            en_we,
    input  logic            en_set_mode,
    input  logic [NSRC-1:0] en_bits,
    output logic [NSRC-1:0] flags_o,
    output logic [NSRC-1:0] enables_o,
    output logic            irq_o
);

    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                if (set_i[i])      flag_q[i] <= 1'b1;
                else if (clr_i[i]) flag_q[i] <= 1'b0;

                if (en_we && en_bits[i]) en_q[i] <= en_set_mode;
            end
        end
    end

    assign flags_o   = flag_q;
    assign enables_o = en_q;
    assign irq_o     = |(flag_q & en_q);

endmodule

// File: rtl/tmr_irq_core.sv
module tmr_irq_core
    import tmr_pkg::*;
#(
    parameter int                  DATA_W     = 8,
    parameter logic [2*DATA_W-1:0] T2_RST_CNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t1_tick,
    input  logic              t2_tick,
    input  logic              sr_set,
    input  logic              cs_wr,
    input  logic              cs_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic              wr_t1_clo, wr_t1_chi, wr_t1_llo, wr_t1_lhi;
    logic              wr_t2_clo, wr_t2_chi, wr_mode, wr_flags, wr_enable;
    logic              rd_t1_clo, rd_t2_clo;
    logic              mode_q;
    logic [CNT_W-1:0]  t1_cnt, t1_lat, t2_cnt, t2_lat;
    logic              t1_exp, t2_exp;
    logic [NSRC-1:0]   flag_set, flag_clr, flag_vec, en_vec, en_pick;
    logic [DATA_W-1:0] flags_byte, enable_byte;

    // Address decode
    assign wr_t1_clo = cs_wr && (addr == ADR_T1_CLO);
    assign wr_t1_chi = cs_wr && (addr == ADR_T1_CHI);
    assign wr_t1_llo = cs_wr && (addr == ADR_T1_LLO);
    assign wr_t1_lhi = cs_wr && (addr == ADR_T1_LHI);
    assign wr_t2_clo = cs_wr && (addr == ADR_T2_CLO);
    assign wr_t2_chi = cs_wr && (addr == ADR_T2_CHI);
    assign wr_mode   = cs_wr && (addr == ADR_MODE);
    assign wr_flags  = cs_wr && (addr == ADR_FLAGS);
    assign wr_enable = cs_wr && (addr == ADR_ENABLE);
    assign rd_t1_clo = cs_rd && (addr == ADR_T1_CLO);
    assign rd_t2_clo = cs_rd && (addr == ADR_T2_CLO);

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (wr_mode) mode_q <= wdata[0];
    end

    tmr_down_cnt #(
        .DATA_W     (DATA_W),
        .CAN_RELOAD (1'b1),
        .RST_CNT    ('1)
    ) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (t1_tick),
        .cont_mode (mode_q),
        .lat_lo_we (wr_t1_clo || wr_t1_llo),
        .lat_hi_we (wr_t1_chi || wr_t1_lhi),
        .load_go   (wr_t1_chi),
        .wdata     (wdata),
        .count     (t1_cnt),
        .latch     (t1_lat),
        .expire    (t1_exp)
    );

    tmr_down_cnt #(
        .DATA_W     (DATA_W),
        .CAN_RELOAD (1'b0),
        .RST_CNT    (T2_RST_CNT)
    ) u_t2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (t2_tick),
        .cont_mode (1'b0),
        .lat_lo_we (wr_t2_clo),
        .lat_hi_we (wr_t2_chi),
        .load_go   (wr_t2_chi),
        .wdata     (wdata),
        .count     (t2_cnt),
        .latch     (t2_lat),
        .expire    (t2_exp)
    );

    always_comb begin
        flag_set         = '0;
        flag_set[SRC_SR] = sr_set;
        flag_set[SRC_T2] = t2_exp;
        flag_set[SRC_T1] = t1_exp;

        flag_clr         = '0;
        flag_clr[SRC_SR] = wr_flags && wdata[BIT_SR];
        flag_clr[SRC_T2] = (wr_flags && wdata[BIT_T2]) || wr_t2_chi || rd_t2_clo;
        flag_clr[SRC_T1] = (wr_flags && wdata[BIT_T1]) || wr_t1_chi || rd_t1_clo;

        en_pick          = '0;
        en_pick[SRC_SR]  = wdata[BIT_SR];
        en_pick[SRC_T2]  = wdata[BIT_T2];
        en_pick[SRC_T1]  = wdata[BIT_T1];
    end

    tmr_flag_ctl #(
        .NSRC (NSRC)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (flag_set),
        .clr_i       (flag_clr),
        .en_we       (wr_enable),
        .en_set_mode (wdata[BIT_TOP]),
        .en_bits     (en_pick),
        .flags_o     (flag_vec),
        .enables_o   (en_vec),
        .irq_o       (irq)
    );

    always_comb begin
        flags_byte          = '0;
        flags_byte[BIT_SR]  = flag_vec[SRC_SR];
        flags_byte[BIT_T2]  = flag_vec[SRC_T2];
        flags_byte[BIT_T1]  = flag_vec[SRC_T1];
        flags_byte[BIT_TOP] = irq;

        enable_byte         = '0;
        enable_byte[BIT_SR] = en_vec[SRC_SR];
        enable_byte[BIT_T2] = en_vec[SRC_T2];
        enable_byte[BIT_T1] = en_vec[SRC_T1];
    end

    always_comb begin
        rdata = '0;
        if (cs_rd) begin
            case (addr)
                ADR_T1_CLO: rdata = t1_cnt[DATA_W-1:0];
                ADR_T1_CHI: rdata = t1_cnt[CNT_W-1:DATA_W];
                ADR_T1_LLO: rdata = t1_lat[DATA_W-1:0];
                ADR_T1_LHI: rdata = t1_lat[CNT_W-1:DATA_W];
                ADR_T2_CLO: rdata = t2_cnt[DATA_W-1:0];
                ADR_T2_CHI: rdata = t2_cnt[CNT_W-1:DATA_W];
                ADR_MODE:   rdata = {{(DATA_W-1){1'b0}}, mode_q};
                ADR_FLAGS:  rdata = flags_byte;
                ADR_ENABLE: rdata = enable_byte;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_irq_core_chk.sv
module tmr_irq_core_chk
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_wr,
    input logic                  cs_rd,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     wdata,
    input logic                  t2_tick,
    input logic                  irq,
    input logic                  mode_q,
    input logic [2*DATA_W-1:0]   t1_cnt,
    input logic [2*DATA_W-1:0]   t1_lat,
    input logic                  t1_exp,
    input logic [2*DATA_W-1:0]   t2_cnt,
    input logic [2*DATA_W-1:0]   t2_lat,
    input logic                  t2_exp,
    input logic [NSRC-1:0]       flag_vec,
    input logic [NSRC-1:0]       en_vec
);

    assert_t2_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_wr && addr == ADR_T2_CHI) |=>
            (t2_cnt == {$past(wdata), $past(t2_lat[DATA_W-1:0])}) && !flag_vec[SRC_T2]);

    assert_t2_lo_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_wr && addr == ADR_T2_CLO && !t2_tick) |=> $stable(t2_cnt));

    assert_t2_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rd && addr == ADR_T2_CLO && !t2_exp) |=> !flag_vec[SRC_T2]);

    assert_no_irq_masked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq);

    assert_irq_has_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_vec != '0));

    assert_oneshot_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_exp && !mode_q) |=> (t1_cnt == '1));

    assert_cont_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_exp && mode_q && !cs_wr) |=> (t1_cnt == $past(t1_lat)));

endmodule

bind tmr_irq_core tmr_irq_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_wr    (cs_wr),
    .cs_rd    (cs_rd),
    .addr     (addr),
    .wdata    (wdata),
    .t2_tick  (t2_tick),
    .irq      (irq),
    .mode_q   (mode_q),
    .t1_cnt   (t1_cnt),
    .t1_lat   (t1_lat),
    .t1_exp   (t1_exp),
    .t2_cnt   (t2_cnt),
    .t2_lat   (t2_lat),
    .t2_exp   (t2_exp),
    .flag_vec (flag_vec),
    .en_vec   (en_vec)
);

// File: tb/tb_tmr_irq_core.sv
`timescale 1ns/1ps
module tb_tmr_irq_core;

    localparam logic [3:0] A_T1_CLO = 4'd0, A_T1_CHI = 4'd1, A_T1_LLO = 4'd2, A_T1_LHI = 4'd3;
    localparam logic [3:0] A_T2_CLO = 4'd4, A_T2_CHI = 4'd5, A_MODE = 4'd6;
    localparam logic [3:0] A_FLAGS = 4'd7, A_ENABLE = 4'd8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t1_tick = 1'b0, t2_tick = 1'b0, sr_set = 1'b0;
    logic       cs_wr = 1'b0, cs_rd = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_irq_core dut (
        .clk(clk), .rst_n(rst_n), .t1_tick(t1_tick), .t2_tick(t2_tick),
        .sr_set(sr_set), .cs_wr(cs_wr), .cs_rd(cs_rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); cs_wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); cs_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); cs_rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); cs_rd = 1'b0;
    endtask

    // which: 1 = first counter, 2 = second counter
    task automatic ticks(input int which, input int n);
        if (n > 0) begin
            @(negedge clk);
            if (which == 1) t1_tick = 1'b1; else t2_tick = 1'b1;
            repeat (n) @(negedge clk);
            t1_tick = 1'b0; t2_tick = 1'b0;
        end
    endtask

    // Reads high byte first so that a low-byte read side effect comes last
    task automatic rd_cnt(input int which, output int v);
        logic [7:0] hi, lo;
        rd(which == 1 ? A_T1_CHI : A_T2_CHI, hi);
        rd(which == 1 ? A_T1_CLO : A_T2_CLO, lo);
        v = {hi, lo};
    endtask

    task automatic flags(output logic [7:0] f);
        rd(A_FLAGS, f);
    endtask

    function automatic logic [7:0] emap(input int e);
        logic [7:0] m = '0;
        m[2] = e[0]; m[5] = e[1]; m[6] = e[2];
        return m;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, f;
        int v;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        flags(f);        chk("R1 flags", f, 8'h00);
        rd(A_ENABLE, d); chk("R1 enables", d, 8'h00);
        rd(A_MODE, d);   chk("R1 mode", d, 8'h00);
        rd(A_T1_LLO, d); chk("R1 t1 latch lo", d, 8'hFF);
        rd(A_T1_LHI, d); chk("R1 t1 latch hi", d, 8'hFF);
        rd_cnt(1, v);    chk("R1 t1 count", v, 16'hFFFF);
        wr(A_T2_CHI, 8'hFF);
        rd_cnt(2, v);    chk("R1 t2 latch lo reset", v, 16'hFFFF);

        // R2 low write touches latch only, R3 high write loads
        wr(A_T2_CLO, 8'h34);
        rd_cnt(2, v);    chk("R2 count kept", v, 16'hFFFF);
        wr(A_T2_CHI, 8'h12);
        rd_cnt(2, v);    chk("R3 loaded latch", v, 16'h1234);

        // R10 first tick leaves second counter alone, and vice versa
        ticks(1, 5);
        rd_cnt(2, v);    chk("R10 t2 unmoved by t1_tick", v, 16'h1234);
        rd_cnt(1, v);    chk("R10 t1 moved by t1_tick", v, 16'hFFFA);
        ticks(2, 3);
        rd_cnt(1, v);    chk("R10 t1 unmoved by t2_tick", v, 16'hFFFA);

        // R6 sweep of second-counter load values; R4/R5/R11 clears alternate
        for (int n = 0; n < 24; n++) begin
            wr(A_T2_CLO, 8'(n));
            wr(A_T2_CHI, 8'h00);
            ticks(2, n);
            flags(f);     chk("R6 no flag before N+1", f[5], 0);
            rd(A_T2_CHI, d); chk("R6 count at zero hi", d, 8'h00);
            ticks(2, 1);
            flags(f);     chk("R6 flag on tick N+1", f[5], 1);
            if (n % 2 == 0) begin
                rd(A_T2_CLO, d); chk("R4 low byte after wrap", d, 8'hFF);
                flags(f);        chk("R4 read clears flag", f[5], 0);
            end else begin
                rd(A_T2_CHI, d); chk("R5 high byte after wrap", d, 8'hFF);
                flags(f);        chk("R5 flag kept", f[5], 1);
                wr(A_FLAGS, 8'h20);
                flags(f);        chk("R11 write one clears", f[5], 0);
            end
        end

        // R3 high write clears a pending flag
        wr(A_T2_CLO, 8'h02); wr(A_T2_CHI, 8'h00);
        ticks(2, 3);
        flags(f);        chk("R3 flag set first", f[5], 1);
        wr(A_T2_CHI, 8'h00);
        flags(f);        chk("R3 high write clears flag", f[5], 0);

        // R7 full wrap after expiry: no reload, no second flag
        ticks(2, 3);
        flags(f);        chk("R7 expiry", f[5], 1);
        wr(A_FLAGS, 8'h20);
        ticks(2, 65536);
        rd_cnt(2, v);    chk("R7 wrapped count", v, 16'hFFFF);
        flags(f);        chk("R7 no second flag", f[5], 0);

        // R8 + R14 one-shot first counter
        wr(A_MODE, 8'h00);
        for (int n = 0; n < 10; n++) begin
            wr(A_T1_CLO, 8'(n));
            wr(A_T1_CHI, 8'h00);
            ticks(1, n + 1);
            flags(f);     chk("R8 one-shot flag", f[6], 1);
            rd(A_T1_CHI, d); chk("R8 wrap hi", d, 8'hFF);
            rd(A_T1_CLO, d); chk("R8 wrap lo", d, 8'hFF);
            flags(f);     chk("R8 read low clears", f[6], 0);
            ticks(1, n + 1);
            flags(f);     chk("R8 no repeat flag", f[6], 0);
            rd_cnt(1, v); chk("R8 counts on", v, 16'hFFFF - (n + 1));
        end
        wr(A_T1_LHI, 8'h00);
        wr(A_T1_LLO, 8'h03);
        rd(A_T1_LLO, d); chk("R14 latch lo", d, 8'h03);
        rd(A_T1_LHI, d); chk("R14 latch hi", d, 8'h00);
        rd(A_T1_CHI, d); chk("R14 latch writes keep count", d, 8'hFF);

        // R9 continuous mode
        wr(A_MODE, 8'h01);
        rd(A_MODE, d);   chk("R9 mode reads back", d, 8'h01);
        for (int n = 1; n < 7; n++) begin
            wr(A_T1_CLO, 8'(n));
            wr(A_T1_CHI, 8'h00);
            for (int k = 0; k < 3; k++) begin
                ticks(1, n);
                flags(f);     chk("R9 not yet", f[6], 0);
                ticks(1, 1);
                flags(f);     chk("R9 repeat flag", f[6], 1);
                rd(A_T1_CHI, d); chk("R9 reload hi", d, 8'h00);
                rd(A_T1_LLO, d); chk("R9 latch kept", d, 8'(n));
                wr(A_FLAGS, 8'h40);
                rd(A_T1_CHI, d); // no side effect
                rd_cnt(1, v); chk("R9 reloaded", v, n);
            end
        end
        wr(A_MODE, 8'h00);
        wr(A_T1_CHI, 8'h00);   // clears any pending first-counter flag

        // R11 test set, set wins over clear
        @(negedge clk); sr_set = 1'b1; @(negedge clk); sr_set = 1'b0;
        flags(f);        chk("R11 sr flag set", f[2], 1);
        @(negedge clk); sr_set = 1'b1; cs_wr = 1'b1; addr = A_FLAGS; wdata = 8'h04;
        @(negedge clk); sr_set = 1'b0; cs_wr = 1'b0;
        flags(f);        chk("R11 set wins", f[2], 1);
        wr(A_FLAGS, 8'h04);
        flags(f);        chk("R11 cleared", f, 8'h00);

        // R12/R13 exhaustive flag x enable sweep
        for (int fl = 0; fl < 8; fl++) begin
            for (int e = 0; e < 8; e++) begin
                wr(A_FLAGS, 8'h64);
                if (fl[0]) begin
                    @(negedge clk); sr_set = 1'b1; @(negedge clk); sr_set = 1'b0;
                end
                if (fl[1]) begin
                    wr(A_T2_CLO, 8'h00); wr(A_T2_CHI, 8'h00); ticks(2, 1);
                end
                if (fl[2]) begin
                    wr(A_T1_CLO, 8'h00); wr(A_T1_CHI, 8'h00); ticks(1, 1);
                end
                wr(A_ENABLE, 8'h64);
                wr(A_ENABLE, 8'h80 | emap(e));
                rd(A_ENABLE, d); chk("R12 enable set mode", d, emap(e));
                chk("R13 irq level", irq, ((fl & e) != 0) ? 1 : 0);
                flags(f);
                chk("R11 flag bits", f & 8'h64, emap(fl));
                chk("R11 bit7 follows irq", f[7], ((fl & e) != 0) ? 1 : 0);
            end
        end
        wr(A_ENABLE, 8'hE4);
        wr(A_ENABLE, 8'h04);
        rd(A_ENABLE, d); chk("R12 clear mode", d, 8'h60);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule